// File: doc/BRIEF.md
# Line-Doubled Low-Resolution Scanout Controller

This block turns a small framebuffer into a raster for a standard monitor. It keeps a pixel counter for each line and a line counter for each frame, and it drives horizontal and vertical sync. During the visible part of the frame it reads one byte per pixel from a synchronous framebuffer port and presents the bytes on an 8-bit pixel bus. Each stored row is shown on two consecutive scanlines, so a buffer of 240 rows fills 480 visible lines.

Vertical timing is handled by a phase machine that is evaluated once per line, at the line's horizontal sync compare point. The phases run back porch, visible, front porch, sync. The line counter is incremented just before each evaluation and cleared when sync ends, so every frame is counted from the start of its back porch. The framebuffer read port has one cycle of latency. Pixel, hsync and vsync all leave the block through the same two-register pipeline, so they stay aligned at the pins.

Top module: `lowres_scanout`

## Requirements
- R1: While reset is held and for two cycles after it is released, pixel is 0 and both syncs sit at their idle level: high for the default active-low polarity. The first line after reset is line 0 of a back porch.
- R2: In a streamed line, pixel h (0 <= h < LINE_PIXELS) equals the framebuffer byte at row address + h. It appears on the pixel bus two cycles after the line's pixel counter reads h. fb_rd is high only while those reads are issued.
- R3: Pixel is 0 whenever no fetched data is being presented. This includes the slot directly after the last pixel of a line and all blanking.
- R4: Hsync is active while the pixel counter lies in [HSYNC_START, HSYNC_END), with the same two-cycle delay as the pixels. By default it is active low. HSYNC_POSITIVE=1 makes it active high, and VSYNC_POSITIVE=1 does the same for vsync.
- R5: The phases advance only in the order back porch, visible, front porch, sync, back porch. Each advance happens at a line's hsync compare point, after the line counter has been incremented.
- R6: The line counter returns to 0 when it reaches VSYNC_END, so a frame is VSYNC_END lines long. Take m as the line's index since the last back porch start. Line m is streamed exactly when VISIBLE_START <= m < VFP_START, and streaming stops from the first front-porch line onward.
- R7: On entering the visible phase, the row address is reloaded with FB_BASE. The first streamed line shows the first stored row.
- R8: During the visible phase, the row address advances by LINE_PIXELS only at evaluations where the incremented line counter is even. Line m therefore shows stored row (m/2 - VISIBLE_START/2), using integer division.
- R9: An advanced row address that reaches FB_BASE + ROWS*LINE_PIXELS wraps to FB_BASE, so the row index above is taken modulo ROWS.
- R10: Vsync is active on lines m with VSYNC_START <= m < VSYNC_END. It changes level only at a line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_rd | output | 1 | Framebuffer read enable |
| fb_addr | output | ADDR_W | Framebuffer read address |
| fb_data | input | PIX_W | Framebuffer read data, one cycle after fb_addr |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| pixel | output | PIX_W | Registered pixel byte |

## Verification
The hardest case to reach from the ports is the row-address wrap. It only occurs once the visible region has used up every stored row, and with the default timing that takes hundreds of lines. The bench therefore uses a very small geometry. The visible region there is longer than twice the stored rows and starts on an odd line, so a single frame covers the singly-shown first row, the doubled rows, the wrap back to base and the front-porch cut-off. Framebuffer bytes are random and never zero, so a wrong row or a missing blanking slot shows up as a byte mismatch. A reset asserted at a random point mid-frame confirms that the vertical state returns to the start of a back porch.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    PH_BACK   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_FRONT  = 2'd2,
    PH_SYNC   = 2'd3
  } vphase_e;

  function automatic vphase_e phase_after(vphase_e p);
    case (p)
      PH_BACK:   return PH_ACTIVE;
      PH_ACTIVE: return PH_FRONT;
      PH_FRONT:  return PH_SYNC;
      default:   return PH_BACK;
    endcase
  endfunction

endpackage

// File: rtl/scan_htimer.sv
module scan_htimer #(
  parameter int H_TOTAL     = 200,
  parameter int LINE_PIXELS = 160,
  parameter int HSYNC_START = 168,
  parameter int HSYNC_END   = 192,
  parameter int HCNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [HCNT_W-1:0] hcount,
  output logic              line_end,
  output logic              line_evt,
  output logic              in_data,
  output logic              hs_win
);

  localparam logic [HCNT_W-1:0] LAST_H  = HCNT_W'(H_TOTAL - 1);
  localparam logic [HCNT_W-1:0] DATA_H  = HCNT_W'(LINE_PIXELS);
  localparam logic [HCNT_W-1:0] HS_ON   = HCNT_W'(HSYNC_START);
  localparam logic [HCNT_W-1:0] HS_OFF  = HCNT_W'(HSYNC_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount <= '0;
    end else if (hcount == LAST_H) begin
      hcount <= '0;
    end else begin
      hcount <= hcount + 1'b1;
    end
  end

  assign line_end = (hcount == LAST_H);
  assign line_evt = (hcount == HS_ON);
  assign in_data  = (hcount < DATA_H);
  assign hs_win   = (hcount >= HS_ON) && (hcount < HS_OFF);

  AST_HCOUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    $past(line_end) |-> (hcount == '0)); // R4

endmodule

// File: rtl/scan_vphase.sv
module scan_vphase
  import scan_pkg::*;
#(
  parameter int LINE_PIXELS   = 160,
  parameter int ROWS          = 240,
  parameter int FB_BASE       = 0,
  parameter int VISIBLE_START = 34,
  parameter int VFP_START     = 514,
  parameter int VSYNC_START   = 524,
  parameter int VSYNC_END     = 526,
  parameter int ADDR_W        = 16,
  parameter int VCNT_W        = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_evt,
  input  logic              line_end,
  output logic              line_on,
  output logic              vs_act,
  output logic [ADDR_W-1:0] row_addr
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(FB_BASE);
  localparam logic [ADDR_W:0]   STEP_X = (ADDR_W+1)'(LINE_PIXELS);
  localparam logic [ADDR_W:0]   END_X  = (ADDR_W+1)'(FB_BASE + ROWS*LINE_PIXELS);
  localparam logic [VCNT_W-1:0] VIS_C  = VCNT_W'(VISIBLE_START);
  localparam logic [VCNT_W-1:0] VFP_C  = VCNT_W'(VFP_START);
  localparam logic [VCNT_W-1:0] VSS_C  = VCNT_W'(VSYNC_START);
  localparam logic [VCNT_W-1:0] VSE_C  = VCNT_W'(VSYNC_END);

  vphase_e           phase;
  logic [VCNT_W-1:0] lcnt;
  logic [VCNT_W-1:0] cnt_inc;
  logic              stream_en;
  logic              vs_tgt;
  logic [ADDR_W:0]   row_sum;
  logic [ADDR_W-1:0] row_adv;

  assign cnt_inc = lcnt + 1'b1;
  assign row_sum = {1'b0, row_addr} + STEP_X;
  assign row_adv = (row_sum >= END_X) ? BASE_A : row_sum[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_BACK;
      lcnt      <= '0;
      stream_en <= 1'b0;
      vs_tgt    <= 1'b0;
      line_on   <= 1'b0;
      vs_act    <= 1'b0;
      row_addr  <= BASE_A;
    end else begin
      if (line_evt) begin
        lcnt <= cnt_inc;
        case (phase)
          PH_BACK: begin
            if (cnt_inc >= VIS_C) begin
              phase     <= PH_ACTIVE;
              row_addr  <= BASE_A;
              stream_en <= 1'b1;
            end
          end
          PH_ACTIVE: begin
            if (cnt_inc >= VFP_C) begin
              phase     <= PH_FRONT;
              stream_en <= 1'b0;
            end else if (!cnt_inc[0]) begin
              row_addr <= row_adv;
            end
          end
          PH_FRONT: begin
            if (cnt_inc >= VSS_C) begin
              phase  <= PH_SYNC;
              vs_tgt <= 1'b1;
            end
          end
          default: begin
            if (cnt_inc >= VSE_C) begin
              phase  <= PH_BACK;
              lcnt   <= '0;
              vs_tgt <= 1'b0;
            end
          end
        endcase
      end
      if (line_end) begin
        line_on <= stream_en;
        vs_act  <= vs_tgt;
      end
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (phase == phase_after($past(phase)))); // R5

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BACK && $past(phase) == PH_SYNC) |-> (lcnt == '0)); // R6

  AST_ROW_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACTIVE && $past(phase) == PH_BACK) |-> (row_addr == BASE_A)); // R7

  AST_ROW_ODD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACTIVE && $past(phase) == PH_ACTIVE && $past(line_evt) && lcnt[0])
      |-> (row_addr == $past(row_addr))); // R8

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, row_addr} < END_X) && (row_addr >= BASE_A)); // R9

  AST_VS_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
    (vs_act != $past(vs_act)) |-> $past(line_end)); // R10

endmodule

// File: rtl/scan_out_pipe.sv
module scan_out_pipe #(
  parameter int PIX_W          = 8,
  parameter bit HSYNC_POSITIVE = 1'b0,
  parameter bit VSYNC_POSITIVE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch,
  input  logic             hs_win,
  input  logic             vs_act,
  input  logic [PIX_W-1:0] fb_data,
  output logic [PIX_W-1:0] pixel,
  output logic             hsync,
  output logic             vsync
);

  logic val_q, hs_q, vs_q;
  logic hs_lvl, vs_lvl;
  logic hs_idle, vs_idle;

  generate
    if (HSYNC_POSITIVE) begin : g_hs_pos
      assign hs_lvl  = hs_q;
      assign hs_idle = 1'b0;
    end else begin : g_hs_neg
      assign hs_lvl  = ~hs_q;
      assign hs_idle = 1'b1;
    end
    if (VSYNC_POSITIVE) begin : g_vs_pos
      assign vs_lvl  = vs_q;
      assign vs_idle = 1'b0;
    end else begin : g_vs_neg
      assign vs_lvl  = ~vs_q;
      assign vs_idle = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= 1'b0;
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      pixel <= '0;
      hsync <= hs_idle;
      vsync <= vs_idle;
    end else begin
      val_q <= fetch;
      hs_q  <= hs_win;
      vs_q  <= vs_act;
      pixel <= val_q ? fb_data : '0;
      hsync <= hs_lvl;
      vsync <= vs_lvl;
    end
  end

  AST_HSYNC_BLANK: assert property (@(posedge clk) disable iff (rst)
    (hsync != hs_idle) |-> (pixel == '0)); // R3

endmodule

// File: rtl/lowres_scanout.sv
module lowres_scanout
  import scan_pkg::*;
#(
  parameter int PIX_W          = 8,
  parameter int LINE_PIXELS    = 160,
  parameter int ROWS           = 240,
  parameter int FB_BASE        = 0,
  parameter int H_TOTAL        = 200,
  parameter int HSYNC_START    = 168,
  parameter int HSYNC_END      = 192,
  parameter int VISIBLE_START  = 34,
  parameter int VFP_START      = 514,
  parameter int VSYNC_START    = 524,
  parameter int VSYNC_END      = 526,
  parameter bit HSYNC_POSITIVE = 1'b0,
  parameter bit VSYNC_POSITIVE = 1'b0,
  localparam int ADDR_W = (FB_BASE + LINE_PIXELS*ROWS) > 1 ? $clog2(FB_BASE + LINE_PIXELS*ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              fb_rd,
  output logic [ADDR_W-1:0] fb_addr,
  input  logic [PIX_W-1:0]  fb_data,
  output logic              hsync,
  output logic              vsync,
  output logic [PIX_W-1:0]  pixel
);

  localparam int HCNT_W = $clog2(H_TOTAL);
  localparam int VCNT_W = $clog2(VSYNC_END + 1);

  // Parameter legality, checked at elaboration.
  if (!(VISIBLE_START > 0 && VISIBLE_START < VFP_START &&
        VFP_START < VSYNC_START && VSYNC_START < VSYNC_END)) begin : g_bad_vertical
    $error("lowres_scanout: vertical thresholds must rise strictly");
  end
  if (!(LINE_PIXELS < HSYNC_START && HSYNC_START < HSYNC_END &&
        HSYNC_END < H_TOTAL)) begin : g_bad_horizontal
    $error("lowres_scanout: hsync must follow the pixel data inside the line");
  end

  logic [HCNT_W-1:0] hcount;
  logic              line_end, line_evt, in_data, hs_win;
  logic              line_on, vs_act;
  logic [ADDR_W-1:0] row_addr;

  scan_htimer #(
    .H_TOTAL     (H_TOTAL),
    .LINE_PIXELS (LINE_PIXELS),
    .HSYNC_START (HSYNC_START),
    .HSYNC_END   (HSYNC_END),
    .HCNT_W      (HCNT_W)
  ) u_htimer (
    .clk      (clk),
    .rst      (rst),
    .hcount   (hcount),
    .line_end (line_end),
    .line_evt (line_evt),
    .in_data  (in_data),
    .hs_win   (hs_win)
  );

  scan_vphase #(
    .LINE_PIXELS   (LINE_PIXELS),
    .ROWS          (ROWS),
    .FB_BASE       (FB_BASE),
    .VISIBLE_START (VISIBLE_START),
    .VFP_START     (VFP_START),
    .VSYNC_START   (VSYNC_START),
    .VSYNC_END     (VSYNC_END),
    .ADDR_W        (ADDR_W),
    .VCNT_W        (VCNT_W)
  ) u_vphase (
    .clk      (clk),
    .rst      (rst),
    .line_evt (line_evt),
    .line_end (line_end),
    .line_on  (line_on),
    .vs_act   (vs_act),
    .row_addr (row_addr)
  );

  assign fb_rd   = line_on & in_data;
  assign fb_addr = row_addr + ADDR_W'(hcount);

  scan_out_pipe #(
    .PIX_W          (PIX_W),
    .HSYNC_POSITIVE (HSYNC_POSITIVE),
    .VSYNC_POSITIVE (VSYNC_POSITIVE)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .fetch   (fb_rd),
    .hs_win  (hs_win),
    .vs_act  (vs_act),
    .fb_data (fb_data),
    .pixel   (pixel),
    .hsync   (hsync),
    .vsync   (vsync)
  );

  AST_FETCH_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    fb_rd |-> !hs_win); // R2

endmodule

// File: tb/lowres_scanout_bench.sv
module lowres_scanout_bench;

  localparam int PW   = 8;
  localparam int LP   = 8;
  localparam int ROWS = 3;
  localparam int BASE = 5;
  localparam int HT   = 16;
  localparam int HSS  = 10;
  localparam int HSE  = 13;
  localparam int VS   = 3;
  localparam int VFP  = 12;
  localparam int VSS  = 14;
  localparam int VSE  = 16;
  localparam int AW   = $clog2(BASE + LP*ROWS);
  localparam int FRAME = HT*VSE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [PW-1:0] mem [0:(1<<AW)-1];
  logic          fb_rd, fb_rd_p;
  logic [AW-1:0] fb_addr, fb_addr_p;
  logic [PW-1:0] fb_data, fb_data_p;
  logic          hsync, vsync, hsync_p, vsync_p;
  logic [PW-1:0] pixel, pixel_p;

  always_ff @(posedge clk) begin
    fb_data   <= mem[fb_addr];
    fb_data_p <= mem[fb_addr_p];
  end

  lowres_scanout #(
    .PIX_W(PW), .LINE_PIXELS(LP), .ROWS(ROWS), .FB_BASE(BASE),
    .H_TOTAL(HT), .HSYNC_START(HSS), .HSYNC_END(HSE),
    .VISIBLE_START(VS), .VFP_START(VFP), .VSYNC_START(VSS), .VSYNC_END(VSE)
  ) u_lowres_scanout (
    .clk(clk), .rst(rst), .fb_rd(fb_rd), .fb_addr(fb_addr), .fb_data(fb_data),
    .hsync(hsync), .vsync(vsync), .pixel(pixel)
  );

  lowres_scanout #(
    .PIX_W(PW), .LINE_PIXELS(LP), .ROWS(ROWS), .FB_BASE(BASE),
    .H_TOTAL(HT), .HSYNC_START(HSS), .HSYNC_END(HSE),
    .VISIBLE_START(VS), .VFP_START(VFP), .VSYNC_START(VSS), .VSYNC_END(VSE),
    .HSYNC_POSITIVE(1'b1), .VSYNC_POSITIVE(1'b1)
  ) u_lowres_scanout_pos (
    .clk(clk), .rst(rst), .fb_rd(fb_rd_p), .fb_addr(fb_addr_p), .fb_data(fb_data_p),
    .hsync(hsync_p), .vsync(vsync_p), .pixel(pixel_p)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  int  k = 0;
  bit  done = 1'b0;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, k);
    end
  endtask

  function automatic bit streamed(int m);
    return (m >= VS) && (m < VFP);
  endfunction

  function automatic int row_steps(int m);
    return (m/2) - (VS/2);
  endfunction

  function automatic int exp_pixel(int m, int h);
    if (streamed(m) && h < LP) return int'(mem[BASE + (row_steps(m) % ROWS)*LP + h]);
    return 0;
  endfunction

  // Outputs seen at cycle k reflect counter cycle t = k-2.
  task automatic check_now();
    int t, ln, h, m, ep;
    string tag;
    t = k - 2;
    if (t < 0) begin
      check("R1", "pixel", int'(pixel), 0);
      check("R1", "hsync", int'(hsync), 1);
      check("R1", "vsync", int'(vsync), 1);
      check("R1", "fb_rd", int'(fb_rd), 0);
      return;
    end
    ln = t / HT;
    h  = t % HT;
    m  = ln % VSE;
    ep = exp_pixel(m, h);
    if (streamed(m) && h < LP) begin
      if (m == VS)                    tag = "R2 R7";
      else if (row_steps(m) >= ROWS)  tag = "R2 R9";
      else                            tag = "R2 R8";
    end else if (streamed(m)) begin
      tag = "R3";
    end else begin
      tag = "R5 R6";
    end
    check(tag, "pixel", int'(pixel), ep);
    check("R4", "hsync", int'(hsync), (h >= HSS && h < HSE) ? 0 : 1);
    check("R4", "hsync positive", int'(hsync_p), (h >= HSS && h < HSE) ? 1 : 0);
    check("R10", "vsync", int'(vsync), (m >= VSS) ? 0 : 1);
    check("R10", "vsync positive", int'(vsync_p), (m >= VSS) ? 1 : 0);
    // fb_rd for counter cycle k: reads issued only inside the data window.
    begin
      int tr, hr, mr;
      tr = k;
      hr = tr % HT;
      mr = (tr / HT) % VSE;
      check("R2", "fb_rd", int'(fb_rd), (streamed(mr) && hr < LP) ? 1 : 0);
    end
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      check_now();
      @(posedge clk);
      k++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(int len);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check("R1", "pixel in reset", int'(pixel), 0);
      check("R1", "hsync in reset", int'(hsync), 1);
      check("R1", "vsync in reset", int'(vsync), 1);
    end
    rst = 1'b0;
    k = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int a = 0; a < (1<<AW); a++) mem[a] = PW'($urandom_range(1, 255));
    do_reset(3);
    run_cycles(3*FRAME);
    // Directed: reset in the middle of the visible region of a frame.
    run_cycles(VS*HT + 5*HT + $urandom_range(0, HT-1));
    do_reset($urandom_range(1, 4));
    run_cycles(2*FRAME);
    // Random-point reset, then one more frame.
    run_cycles($urandom_range(1, FRAME-1));
    do_reset($urandom_range(1, 4));
    run_cycles(FRAME + 4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: got 0 expected 1 (run did not complete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule